// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block is the interrupt unit of a host controller. It holds two 32-bit words. The first is an enable word that software reaches through two aliased addresses. At the set address a 1 turns a bit on. At the clear address a 1 turns a bit off. Both addresses read back the same enable value. The second is a status word. One-cycle event pulses from the controller's sources set its bits, and software clears a bit by writing 1 to it at the status address.

A single interrupt line leaves the block. It is high while the master enable bit is on and at least one source has both its status bit and its enable bit set. Source positions are fixed:

| Bit | Source |
|-----|--------|
| 0 | scheduling overrun |
| 1 | done-queue write-back |
| 2 | start of frame |
| 3 | resume detected |
| 4 | unrecoverable error |
| 5 | frame counter overflow |
| 6 | root port status change |
| 30 | ownership change |
| 31 | master enable (enable word only) |

Bits 7 to 29 are reserved.

Top module: `intr_enable_ctl`

## Requirements
- R1: After a synchronous active-high reset, the enable word, the status word and `irq` are all 0.
- R2: A write to address 1 (enable set) sets every enable bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read at address 1 returns the enable word.
- R3: A write to address 2 (enable clear) clears every enable bit whose write-data bit is 1 and leaves the bits written 0 unchanged. A read at address 2 returns the same enable word as address 1.
- R4: Reserved bits 7 to 29 of both words always read as 0 and ignore writes. Status bit 31 always reads 0. Writes to address 3 change nothing, and reads at address 3 return 0.
- R5: A 1 on `evt_in[k]` in a cycle, for a source position k in {0..6, 30}, sets status bit k at that clock edge. Address 0 reads the status word.
- R6: A write to address 0 clears each status bit written 1 and leaves each status bit written 0 unchanged.
- R7: If an event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when enable bit 31 is 1 and some source bit is 1 in both the status and enable words. With bit 31 at 0, `irq` stays 0 whatever the status holds.
- R9: A source whose enable bit is 0 does not raise `irq`, even if its status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 2 | Register select: 0 status, 1 enable set, 2 enable clear, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 32 | One-cycle source event pulses, by status bit position |
| irq | output | 1 | Interrupt request line |

## Verification
Every register write and every event pulse takes effect at the clock edge it is presented on. Both `bus_rdata` and `irq` are combinational from the two words, so each result is due one edge after its stimulus. The bench drives a stimulus on a falling edge and lets one rising edge pass. It then removes the write strobe, points `bus_addr` at the register to be inspected, and samples shortly after that falling edge. This way a check never overlaps a clock edge. The reset checks are taken at the same point after reset has been released.

// File: rtl/intr_enable_ctl.sv
module intr_enable_ctl #(
  parameter int          DW         = 32,
  parameter int          AW         = 2,
  parameter logic [31:0] SRC_MASK   = 32'h4000_007F,
  parameter int          MASTER_BIT = 31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_in,
  output logic          irq
);
  localparam logic [DW-1:0] SRC_M   = SRC_MASK[DW-1:0];
  localparam logic [DW-1:0] EN_MASK = SRC_M | (DW'(1) << MASTER_BIT);
  localparam logic [AW-1:0] A_STS   = AW'(0);
  localparam logic [AW-1:0] A_SET   = AW'(1);
  localparam logic [AW-1:0] A_CLR   = AW'(2);

  logic [DW-1:0] en_q, sts_q;
  logic          wr_sts, wr_set, wr_clr;

  assign wr_sts = bus_wr && (bus_addr == A_STS);
  assign wr_set = bus_wr && (bus_addr == A_SET);
  assign wr_clr = bus_wr && (bus_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr_set)
        en_q <= (en_q | bus_wdata) & EN_MASK;
      else if (wr_clr)
        en_q <= en_q & ~bus_wdata;
      sts_q <= ((sts_q & ~(wr_sts ? bus_wdata : '0)) | evt_in) & SRC_M;
    end
  end

  assign irq = en_q[MASTER_BIT] & |(sts_q & en_q & SRC_M);

  always_comb begin
    unique case (bus_addr)
      A_STS:        bus_rdata = sts_q;
      A_SET, A_CLR: bus_rdata = en_q;
      default:      bus_rdata = '0;
    endcase
  end
endmodule

module intr_enable_ctl_chk #(
  parameter int          DW         = 32,
  parameter int          AW         = 2,
  parameter logic [31:0] SRC_MASK   = 32'h4000_007F,
  parameter int          MASTER_BIT = 31
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] evt_in,
  input logic [DW-1:0] en,
  input logic [DW-1:0] sts,
  input logic          irq
);
  localparam logic [DW-1:0] SRC_M   = SRC_MASK[DW-1:0];
  localparam logic [DW-1:0] EN_MASK = SRC_M | (DW'(1) << MASTER_BIT);

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(1)) |=>
      ((en & ($past(bus_wdata) & EN_MASK)) == ($past(bus_wdata) & EN_MASK)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(2)) |=>
      ((en & $past(bus_wdata)) == '0 &&
       (en & ~$past(bus_wdata)) == ($past(en) & ~$past(bus_wdata))));

  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((en & ~EN_MASK) == '0) && ((sts & ~SRC_M) == '0));

  // R5
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((evt_in & SRC_M) != '0) |=>
      ((sts & $past(evt_in & SRC_M)) == $past(evt_in & SRC_M)));

  // R8
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !en[MASTER_BIT] |-> !irq);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((sts & en & SRC_M) != '0));
endmodule

bind intr_enable_ctl intr_enable_ctl_chk #(
  .DW(DW), .AW(AW), .SRC_MASK(SRC_MASK), .MASTER_BIT(MASTER_BIT)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .evt_in(evt_in), .en(en_q), .sts(sts_q), .irq(irq)
);

// File: tb/intr_enable_ctl_bench.sv
`timescale 1ns/1ps
module intr_enable_ctl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, evt_in;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  always #4 clk = ~clk;

  intr_enable_ctl u_intr_enable_ctl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  // {wr, addr, wdata, evt, rd_addr, exp_rdata, exp_irq}
  localparam int NV = 12;
  localparam logic [101:0] VEC [NV] = '{
    {1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0,         2'd1, 32'hC000_007F, 1'b0}, // R2 R4
    {1'b1, 2'd2, 32'h0000_0003, 32'h0,         2'd2, 32'hC000_007C, 1'b0}, // R3
    {1'b0, 2'd0, 32'h0,         32'h0000_0001, 2'd0, 32'h0000_0001, 1'b0}, // R5 R9
    {1'b0, 2'd0, 32'h0,         32'h0000_0004, 2'd0, 32'h0000_0005, 1'b1}, // R5 R8
    {1'b1, 2'd2, 32'h8000_0000, 32'h0,         2'd1, 32'h4000_007C, 1'b0}, // R3 R8
    {1'b1, 2'd1, 32'h8000_0000, 32'h0,         2'd2, 32'hC000_007C, 1'b1}, // R2 R8
    {1'b1, 2'd0, 32'h0000_0004, 32'h0,         2'd0, 32'h0000_0001, 1'b0}, // R6
    {1'b1, 2'd0, 32'h0000_0001, 32'h0000_0001, 2'd0, 32'h0000_0001, 1'b0}, // R7
    {1'b0, 2'd0, 32'h0,         32'hFFFF_FFFF, 2'd0, 32'h4000_007F, 1'b1}, // R5 R4
    {1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0,         2'd3, 32'h0000_0000, 1'b1}, // R4
    {1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0,         2'd0, 32'h0000_0000, 1'b0}, // R6
    {1'b1, 2'd1, 32'h0,         32'h0,         2'd1, 32'hC000_007C, 1'b0}  // R2
  };
  localparam string VREQ [NV] = '{"R2", "R3", "R5", "R5", "R3", "R2",
                                  "R6", "R7", "R5", "R4", "R6", "R2"};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, input logic [31:0] exp_rd,
                      input logic exp_irq, input string req);
    bus_wr   = 1'b0;
    bus_addr = a;
    evt_in   = '0;
    #1;
    check(req, bus_rdata, exp_rd, "rdata");
    check(req, 32'(irq), 32'(exp_irq), "irq");
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state at every address
    peek(2'd0, 32'h0, 1'b0, "R1");
    peek(2'd1, 32'h0, 1'b0, "R1");
    peek(2'd2, 32'h0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr    = VEC[i][101];
      bus_addr  = VEC[i][100:99];
      bus_wdata = VEC[i][98:67];
      evt_in    = VEC[i][66:35];
      @(negedge clk);
      peek(VEC[i][34:33], VEC[i][32:1], VEC[i][0], VREQ[i]);
    end

    // R4: reserved status bit 31 and reserved events leave status unchanged
    @(negedge clk) evt_in = 32'h8000_0080;
    @(negedge clk) peek(2'd0, 32'h0, 1'b0, "R4");

    // R8: enabled source raised while master is on drives irq
    @(negedge clk) evt_in = 32'h4000_0000;
    @(negedge clk) peek(2'd0, 32'h4000_0000, 1'b1, "R8");

    // R1: reset mid-run wipes both words
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    peek(2'd1, 32'h0, 1'b0, "R1");
    peek(2'd0, 32'h0, 1'b0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule